// File: doc/BRIEF.md
# Lamp Ballast Mode Sequencer

This block is the digital heart of a resonant lamp ballast controller. It walks the half-bridge through its operating phases: an off/lockout state, a filament preheat phase, an ignition frequency ramp, steady run, and a latched fault state. Its inputs are single-bit comparator results: supply above the rising lockout level, supply below the falling lockout level, bus voltage good, shutdown pin high, over-temperature, current above the upper sense limit, and current below the lower sense limit. Before any of these is used, it passes through a two-flop synchroniser.

Preheat and ignition are timed by one internal counter in place of a charging capacitor. Preheat lasts `PH_COUNT` cycles. The ignition ramp continues on the same counter up to five quarters of that count, so the ramp is always one quarter as long as preheat. The outputs are the present mode, an oscillator enable, a two-bit frequency-select code for the external oscillator, and the arming signals for the upper and lower current-sense comparators.

Supply, bus and shutdown problems send the block back to lockout, and it restarts by itself once they clear. Over-temperature and armed current-sense trips latch the block in fault mode until the lamp is pulled (shutdown high) or the supply collapses.

Top module: `ballast_seq`

## Requirements
- R1: While reset is asserted and in lockout, `mode_o`=0, `osc_en_o`=0, `freq_sel_o`=0 and both sense enables are 0. The mode codes are 0 lockout, 1 preheat, 2 ramp, 3 run, 4 fault.
- R2: Lockout is left only when `uv_rise_i`=1, `bus_ok_i`=1, `sd_i`=0 and `uv_fall_i`=0 all hold together. Because of the synchroniser, the mode changes to preheat on the third rising edge after the inputs change. Preheat starts with the timer cleared.
- R3: Preheat lasts exactly `PH_COUNT` cycles, ramp lasts `PH_COUNT/4` cycles, and run follows. `freq_sel_o` is 0 (start) for the first `START_CYC` cycles of preheat and 1 for the rest of preheat. It is 2 in ramp and 3 in run.
- R4: `cs_hi_en_o` is 1 in ramp and in run, and 0 in every other mode.
- R5: `cs_lo_en_o` is 1 only in run.
- R6: In preheat, ramp or run, any of `uv_fall_i`=1, `bus_ok_i`=0 or `sd_i`=1 moves the block to lockout three edges later, with no latching. When the start conditions return, the sequence begins again at preheat with the start frequency.
- R7: `ovt_i` in any active mode, `oc_hi_i` in ramp or run, and `oc_lo_i` in run each force fault mode, even from a one-cycle pulse. `oc_hi_i` during preheat and `oc_lo_i` during preheat or ramp have no effect.
- R8: Fault mode holds while the bus is low, while the rising-level flag is low and while all start conditions are met. It moves to lockout only on `sd_i`=1 or `uv_fall_i`=1.
- R9: `osc_en_o` is 1 exactly in preheat, ramp and run. In fault mode the oscillator enable, frequency code and sense enables are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| uv_rise_i | input | 1 | Supply above rising lockout level |
| uv_fall_i | input | 1 | Supply below falling lockout level |
| bus_ok_i | input | 1 | Bus voltage good |
| sd_i | input | 1 | Shutdown / lamp-absent pin high |
| ovt_i | input | 1 | Over-temperature |
| oc_hi_i | input | 1 | Sense current above upper limit |
| oc_lo_i | input | 1 | Sense current below lower limit |
| mode_o | output | 3 | Present mode code |
| osc_en_o | output | 1 | Oscillator / half-bridge enable |
| freq_sel_o | output | 2 | 0 start, 1 preheat, 2 ramp, 3 run |
| cs_hi_en_o | output | 1 | Upper sense comparator armed |
| cs_lo_en_o | output | 1 | Lower sense comparator armed |

## Verification
All eight combinations of supply, bus and shutdown are applied from lockout. This shows that only the full start condition leaves lockout, and it also pins down the three-edge synchroniser latency. Each unlatched cause and each latching source is injected in each of the three active modes. Armed sense trips must latch, while unarmed ones must let the sequence carry on, so the checks separate arming by mode from plain trip detection. A cycle-by-cycle profile of one full start-up confirms the preheat and ramp lengths and the 1:4 ratio between them. Fault mode is then probed with each input that must not release it, and with the two that must.

// File: rtl/ballast_seq.sv
module ballast_seq #(
  parameter int PH_COUNT  = 64,
  parameter int START_CYC = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       uv_rise_i,
  input  logic       uv_fall_i,
  input  logic       bus_ok_i,
  input  logic       sd_i,
  input  logic       ovt_i,
  input  logic       oc_hi_i,
  input  logic       oc_lo_i,
  output logic [2:0] mode_o,
  output logic       osc_en_o,
  output logic [1:0] freq_sel_o,
  output logic       cs_hi_en_o,
  output logic       cs_lo_en_o
);

  localparam int RAMP_END = PH_COUNT + PH_COUNT / 4;
  localparam int TW       = $clog2(RAMP_END + 1);

  localparam logic [2:0] M_OFF   = 3'd0;
  localparam logic [2:0] M_PRE   = 3'd1;
  localparam logic [2:0] M_RAMP  = 3'd2;
  localparam logic [2:0] M_RUN   = 3'd3;
  localparam logic [2:0] M_FAULT = 3'd4;

  logic [6:0] raw, s1, s2;
  assign raw = {oc_lo_i, oc_hi_i, ovt_i, sd_i, bus_ok_i, uv_fall_i, uv_rise_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= raw;
      s2 <= s1;
    end
  end

  logic uvr, uvf, bus, sd, ovt, ochi, oclo;
  assign {oclo, ochi, ovt, sd, bus, uvf, uvr} = s2;

  logic [2:0]    mode, mode_n;
  logic [TW-1:0] tmr, tmr_n;

  wire drop = uvf | ~bus | sd;
  wire trip = ovt | (ochi & (mode == M_RAMP || mode == M_RUN)) | (oclo & (mode == M_RUN));

  always_comb begin
    mode_n = mode;
    tmr_n  = tmr;
    case (mode)
      M_OFF: begin
        tmr_n = '0;
        if (uvr & ~uvf & bus & ~sd) mode_n = M_PRE;
      end
      M_PRE, M_RAMP, M_RUN: begin
        if (drop) begin
          mode_n = M_OFF;
          tmr_n  = '0;
        end else if (trip) begin
          mode_n = M_FAULT;
          tmr_n  = '0;
        end else begin
          if (mode != M_RUN) tmr_n = tmr + TW'(1);
          if (mode == M_PRE && tmr == TW'(PH_COUNT - 1)) mode_n = M_RAMP;
          if (mode == M_RAMP && tmr == TW'(RAMP_END - 1)) mode_n = M_RUN;
        end
      end
      M_FAULT: begin
        tmr_n = '0;
        if (sd | uvf) mode_n = M_OFF;
      end
      default: begin
        mode_n = M_OFF;
        tmr_n  = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= M_OFF;
      tmr  <= '0;
    end else begin
      mode <= mode_n;
      tmr  <= tmr_n;
    end
  end

  assign mode_o     = mode;
  assign osc_en_o   = (mode == M_PRE) || (mode == M_RAMP) || (mode == M_RUN);
  assign cs_hi_en_o = (mode == M_RAMP) || (mode == M_RUN);
  assign cs_lo_en_o = (mode == M_RUN);

  always_comb begin
    case (mode)
      M_PRE:   freq_sel_o = (tmr < TW'(START_CYC)) ? 2'd0 : 2'd1;
      M_RAMP:  freq_sel_o = 2'd2;
      M_RUN:   freq_sel_o = 2'd3;
      default: freq_sel_o = 2'd0;
    endcase
  end

endmodule

// File: rtl/ballast_seq_chk.sv
module ballast_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode_o,
  input logic       osc_en_o,
  input logic       cs_hi_en_o,
  input logic       cs_lo_en_o
);

  p_mode_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o <= 3'd4);

  p_pre_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd1 && $past(mode_o) != 3'd1) |-> $past(mode_o) == 3'd0);

  p_run_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd3 && $past(mode_o) != 3'd3) |-> $past(mode_o) == 3'd2);

  p_lo_implies_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_lo_en_o |-> cs_hi_en_o);

  p_fault_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd4) |=> (mode_o == 3'd4 || mode_o == 3'd0));

  p_fault_dark_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd4) |=> !osc_en_o);

endmodule

bind ballast_seq ballast_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_o(mode_o), .osc_en_o(osc_en_o),
  .cs_hi_en_o(cs_hi_en_o), .cs_lo_en_o(cs_lo_en_o)
);

// File: tb/ballast_seq_test.sv
module ballast_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int PH = 16;
  localparam int ST = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic uv_rise = 0, uv_fall = 1, bus_ok = 0, sd = 1, ovt = 0, oc_hi = 0, oc_lo = 0;
  logic [2:0] mode;
  logic osc_en, cs_hi_en, cs_lo_en;
  logic [1:0] freq_sel;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ballast_seq #(.PH_COUNT(PH), .START_CYC(ST)) uut (
    .clk(clk), .rst_n(rst_n), .uv_rise_i(uv_rise), .uv_fall_i(uv_fall),
    .bus_ok_i(bus_ok), .sd_i(sd), .ovt_i(ovt), .oc_hi_i(oc_hi), .oc_lo_i(oc_lo),
    .mode_o(mode), .osc_en_o(osc_en), .freq_sel_o(freq_sel),
    .cs_hi_en_o(cs_hi_en), .cs_lo_en_o(cs_lo_en));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    uv_rise = 1; uv_fall = 0; bus_ok = 1; sd = 1;
    ovt = 0; oc_hi = 0; oc_lo = 0;
    step(4);
  endtask

  task automatic go(input int m);
    uv_rise = 1; uv_fall = 0; bus_ok = 1; sd = 0;
    step(3);
    if (m == 2) step(PH);
    if (m == 3) step(PH + PH/4);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    step(3);
    chk("R1 reset mode", mode, 0);
    chk("R1 reset osc", osc_en, 0);
    chk("R1 reset freq", freq_sel, 0);
    chk("R1 reset cs_hi", cs_hi_en, 0);
    chk("R1 reset cs_lo", cs_lo_en, 0);
    rst_n = 1;
    step(4);
    chk("R1 lockout mode", mode, 0);

    // R2: start condition sweep
    for (int c = 0; c < 8; c++) begin
      idle();
      uv_rise = c[0]; bus_ok = c[1]; sd = c[2];
      step(2);
      chk("R2 latency", mode, 0);
      step(1);
      chk("R2 start decode", mode, (c == 3) ? 1 : 0);
      if (c == 3) chk("R2 timer cleared", freq_sel, 0);
    end

    // R3 R4 R5 R9: full start-up profile
    idle();
    go(1);
    for (int i = 0; i < 28; i++) begin
      chk("R3 mode profile", mode, (i < PH) ? 1 : (i < PH + PH/4) ? 2 : 3);
      chk("R3 freq profile", freq_sel, (i < ST) ? 0 : (i < PH) ? 1 : (i < PH + PH/4) ? 2 : 3);
      chk("R4 cs_hi arm", cs_hi_en, (i >= PH) ? 1 : 0);
      chk("R5 cs_lo arm", cs_lo_en, (i >= PH + PH/4) ? 1 : 0);
      chk("R9 osc active", osc_en, 1);
      step(1);
    end

    // R6: unlatched exits
    for (int m = 1; m <= 3; m++)
      for (int k = 0; k < 3; k++) begin
        idle();
        go(m);
        chk("R6 reached mode", mode, m);
        if (k == 0) begin uv_fall = 1; uv_rise = 0; end
        if (k == 1) bus_ok = 0;
        if (k == 2) sd = 1;
        step(2);
        chk("R6 sync delay", mode, m);
        step(1);
        chk("R6 to lockout", mode, 0);
        chk("R9 lockout osc", osc_en, 0);
        step(3);
        chk("R6 stays off", mode, 0);
        uv_fall = 0; uv_rise = 1; bus_ok = 1; sd = 0;
        step(3);
        chk("R6 restart mode", mode, 1);
        chk("R6 restart freq", freq_sel, 0);
      end

    // R7: latched sources and arming
    for (int m = 1; m <= 3; m++)
      for (int s = 0; s < 3; s++) begin
        bit armed;
        armed = (s == 0) || (s == 1 && m >= 2) || (s == 2 && m == 3);
        idle();
        go(m);
        if (s == 0) ovt = 1;
        if (s == 1) oc_hi = 1;
        if (s == 2) oc_lo = 1;
        step(1);
        ovt = 0; oc_hi = 0; oc_lo = 0;
        step(2);
        chk("R7 trip decision", mode, armed ? 4 : m);
        step(8);
        chk("R7 latched or ignored", mode, armed ? 4 : (m == 1 ? 1 : 3));
        if (armed) begin
          chk("R9 fault osc", osc_en, 0);
          chk("R9 fault freq", freq_sel, 0);
          chk("R9 fault cs_hi", cs_hi_en, 0);
          chk("R9 fault cs_lo", cs_lo_en, 0);
        end
      end

    // R8: fault hold and release
    idle();
    go(3);
    ovt = 1; step(1); ovt = 0; step(2);
    chk("R8 fault entered", mode, 4);
    bus_ok = 0; step(5);
    chk("R8 bus low holds", mode, 4);
    bus_ok = 1; uv_rise = 0; step(5);
    chk("R8 rise flag low holds", mode, 4);
    uv_rise = 1; step(5);
    chk("R8 no auto restart", mode, 4);
    sd = 1; step(3);
    chk("R8 sd releases", mode, 0);
    sd = 0; step(3);
    chk("R8 restart after sd", mode, 1);
    idle();
    go(2);
    oc_hi = 1; step(1); oc_hi = 0; step(2);
    chk("R8 fault from ramp", mode, 4);
    uv_fall = 1; step(3);
    chk("R8 supply collapse releases", mode, 0);
    uv_fall = 0; step(3);
    chk("R8 restart after supply", mode, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule